// File: doc/BRIEF.md
# Superscalar Instruction Grouping Unit

This block sits in the dispatch stage of a four-wide in-order pipeline. Each cycle it looks at up to four candidate instructions, held oldest first in slots 0 to 3, and picks the longest run of them, starting at slot 0, that can go to the execution units together. The first candidate that cannot issue ends the group, so no younger instruction overtakes an older one. A candidate is held back by three things: a third floating-point/graphics instruction in the same group, a source register that an older member of the group writes, or a source register whose youngest in-flight producer cannot yet forward its result.

The in-flight producers are described by a three-entry scoreboard, entry 0 youngest. For every issued slot the block compares both source registers with the scoreboard destinations and gives a bypass select per operand. It also marks each issued slot for the integer or the floating-point/graphics side. A stall from the downstream stage empties the group for that cycle. All outputs are registered, so a decision appears one clock after the candidates are presented.

Top module: `gu_issue_group`

## Requirements
- R1: All outputs are registered: they reflect the inputs present at the previous rising clock edge. While `rst_n` is low, `issue_cnt`, both route masks and both select buses are zero.
- R2: `issue_cnt` (0 to 4) is the number of leading slots, from slot 0 upward, that issue. A slot with `cand_vld` low ends the group even when younger slots are valid.
- R3: A group holds at most two instructions with `cand_fpg` set to 1 (floating-point/graphics). A third one ends the group at its slot.
- R4: For each source of a candidate, the youngest valid scoreboard entry (lowest index) whose destination equals that source decides the outcome. If that entry has `sb_rdy` low, the candidate and all younger slots are not issued.
- R5: A candidate with a source equal to `cand_rd` of an older slot in the same group that has `cand_wr` set is not issued, and it ends the group.
- R6: Register number 0 never matches: it causes no scoreboard interlock, no in-group dependency and a bypass select of 0.
- R7: `byp_sel_a` and `byp_sel_b` hold one 2-bit code per slot (slot i at bits [2i+1:2i]) for source `rs1` and `rs2`: 0 means the register file, k in 1..3 means scoreboard entry k-1, the youngest matching valid entry. Slot fields of slots that do not issue are 0.
- R8: For an issued slot, exactly one of `route_int` and `route_fpg` is set, chosen by `cand_fpg`; the bits of slots that do not issue are 0.
- R9: When `stall_in` is high, the following cycle shows `issue_cnt` of 0 and all route and select bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_in | input | 1 | Downstream stage cannot accept a group |
| cand_vld | input | 4 | Candidate valid, bit i for slot i (slot 0 oldest) |
| cand_fpg | input | 4 | Candidate is floating-point/graphics (1) or integer (0) |
| cand_rs1 | input | 20 | First source register per slot, slot i at bits [5i+4:5i] |
| cand_rs2 | input | 20 | Second source register per slot |
| cand_rd | input | 20 | Destination register per slot |
| cand_wr | input | 4 | Candidate writes its destination |
| sb_vld | input | 3 | Scoreboard entry holds an in-flight result (entry 0 youngest) |
| sb_rd | input | 15 | Scoreboard destination register per entry |
| sb_rdy | input | 3 | Scoreboard result can be forwarded now |
| issue_cnt | output | 3 | Number of slots issued this cycle |
| route_int | output | 4 | Issued slot goes to an integer unit |
| route_fpg | output | 4 | Issued slot goes to the floating-point/graphics unit |
| byp_sel_a | output | 8 | Bypass select for source 1, 2 bits per slot |
| byp_sel_b | output | 8 | Bypass select for source 2, 2 bits per slot |

## Verification
On every cycle the assertions check the shape of the result: the routed slots form a prefix whose length equals the issue count, the two route masks never overlap, no more than two slots go to the floating-point/graphics side, a stall yields an empty group, a nonzero bypass select only names a scoreboard entry that was valid and ready, and unissued slots carry no select. Whether the cut falls at the right slot, that is, whether a particular interlock, in-group dependency or register 0 source was judged correctly, and whether the youngest of several matching entries was chosen, can only be shown by the bench comparing against its own model over directed and random candidate mixes.

// File: rtl/gu_pkg.sv
package gu_pkg;

  localparam int REG_W = 5;

  // A register number matches only when nonzero and equal.
  function automatic logic reg_match(input logic [REG_W-1:0] src,
                                     input logic [REG_W-1:0] dst);
    return (src != '0) && (src == dst);
  endfunction

  // True when adding one more FP/graphics op still fits the limit.
  function automatic logic fpg_fits(input int unsigned used,
                                    input logic          is_fpg,
                                    input int unsigned   limit);
    return (used + (is_fpg ? 1 : 0)) <= limit;
  endfunction

endpackage

// File: rtl/gu_sb_lookup.sv
module gu_sb_lookup #(
  parameter int NSB = 3,
  parameter int RW  = gu_pkg::REG_W,
  parameter int SW  = $clog2(NSB + 1)
) (
  input  logic [RW-1:0]     src,
  input  logic [NSB-1:0]    sb_vld,
  input  logic [NSB*RW-1:0] sb_rd,
  input  logic [NSB-1:0]    sb_rdy,
  output logic              hit,
  output logic              hit_rdy,
  output logic [SW-1:0]     sel
);
  import gu_pkg::*;

  // Walk from oldest to youngest so the youngest match wins.
  always_comb begin
    hit     = 1'b0;
    hit_rdy = 1'b0;
    sel     = '0;
    for (int k = NSB - 1; k >= 0; k--) begin
      if (sb_vld[k] && reg_match(src, sb_rd[k*RW +: RW])) begin
        hit     = 1'b1;
        hit_rdy = sb_rdy[k];
        sel     = SW'(k + 1);
      end
    end
  end

endmodule

// File: rtl/gu_slot_hazard.sv
module gu_slot_hazard #(
  parameter int SLOT  = 0,
  parameter int NSLOT = 4,
  parameter int NSB   = 3,
  parameter int RW    = gu_pkg::REG_W,
  parameter int SW    = $clog2(NSB + 1)
) (
  input  logic [RW-1:0]       rs1,
  input  logic [RW-1:0]       rs2,
  input  logic [NSLOT*RW-1:0] all_rd,
  input  logic [NSLOT-1:0]    all_wr,
  input  logic [NSB-1:0]      sb_vld,
  input  logic [NSB*RW-1:0]   sb_rd,
  input  logic [NSB-1:0]      sb_rdy,
  output logic                dep_hold,
  output logic                sb_hold,
  output logic [SW-1:0]       sel_a,
  output logic [SW-1:0]       sel_b
);
  import gu_pkg::*;

  logic hit_a, rdy_a, hit_b, rdy_b;

  gu_sb_lookup #(.NSB(NSB), .RW(RW), .SW(SW)) look_a_i (
    .src(rs1), .sb_vld(sb_vld), .sb_rd(sb_rd), .sb_rdy(sb_rdy),
    .hit(hit_a), .hit_rdy(rdy_a), .sel(sel_a)
  );

  gu_sb_lookup #(.NSB(NSB), .RW(RW), .SW(SW)) look_b_i (
    .src(rs2), .sb_vld(sb_vld), .sb_rd(sb_rd), .sb_rdy(sb_rdy),
    .hit(hit_b), .hit_rdy(rdy_b), .sel(sel_b)
  );

  assign sb_hold = (hit_a && !rdy_a) || (hit_b && !rdy_b);

  // Older writers in the same group cannot be forwarded in time.
  always_comb begin
    dep_hold = 1'b0;
    for (int j = 0; j < NSLOT; j++) begin
      if (j < SLOT && all_wr[j] &&
          (reg_match(rs1, all_rd[j*RW +: RW]) ||
           reg_match(rs2, all_rd[j*RW +: RW])))
        dep_hold = 1'b1;
    end
  end

endmodule

// File: rtl/gu_prefix.sv
module gu_prefix #(
  parameter int NSLOT   = 4,
  parameter int MAX_FPG = 2,
  parameter int CW      = $clog2(NSLOT + 1)
) (
  input  logic [NSLOT-1:0] vld,
  input  logic [NSLOT-1:0] fpg,
  input  logic [NSLOT-1:0] blk,
  output logic [NSLOT-1:0] mask,
  output logic [CW-1:0]    cnt,
  output logic [NSLOT-1:0] fpg_cut
);
  import gu_pkg::*;

  always_comb begin
    logic        open;
    int unsigned used;
    open    = 1'b1;
    used    = 0;
    mask    = '0;
    fpg_cut = '0;
    cnt     = '0;
    for (int i = 0; i < NSLOT; i++) begin
      fpg_cut[i] = !fpg_fits(used, fpg[i], MAX_FPG);
      if (open && vld[i] && !blk[i] && !fpg_cut[i]) begin
        mask[i] = 1'b1;
        cnt     = cnt + 1'b1;
        used    = used + (fpg[i] ? 1 : 0);
      end else begin
        open = 1'b0;
      end
    end
  end

endmodule

// File: rtl/gu_issue_group.sv
module gu_issue_group #(
  parameter int NSLOT   = 4,
  parameter int NSB     = 3,
  parameter int RW      = gu_pkg::REG_W,
  parameter int MAX_FPG = 2,
  localparam int CW     = $clog2(NSLOT + 1),
  localparam int SW     = $clog2(NSB + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall_in,
  input  logic [NSLOT-1:0]    cand_vld,
  input  logic [NSLOT-1:0]    cand_fpg,
  input  logic [NSLOT*RW-1:0] cand_rs1,
  input  logic [NSLOT*RW-1:0] cand_rs2,
  input  logic [NSLOT*RW-1:0] cand_rd,
  input  logic [NSLOT-1:0]    cand_wr,
  input  logic [NSB-1:0]      sb_vld,
  input  logic [NSB*RW-1:0]   sb_rd,
  input  logic [NSB-1:0]      sb_rdy,
  output logic [CW-1:0]       issue_cnt,
  output logic [NSLOT-1:0]    route_int,
  output logic [NSLOT-1:0]    route_fpg,
  output logic [NSLOT*SW-1:0] byp_sel_a,
  output logic [NSLOT*SW-1:0] byp_sel_b
);

  // Named internal events
  logic [NSLOT-1:0]    dep_hold_w;
  logic [NSLOT-1:0]    sb_hold_w;
  logic [NSLOT-1:0]    blk_w;
  logic [NSLOT-1:0]    fpg_cut_w;
  logic [NSLOT-1:0]    grp_mask_w;
  logic [CW-1:0]       grp_cnt_w;
  logic [NSLOT*SW-1:0] raw_sel_a_w;
  logic [NSLOT*SW-1:0] raw_sel_b_w;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    gu_slot_hazard #(
      .SLOT(i), .NSLOT(NSLOT), .NSB(NSB), .RW(RW), .SW(SW)
    ) hz_i (
      .rs1     (cand_rs1[i*RW +: RW]),
      .rs2     (cand_rs2[i*RW +: RW]),
      .all_rd  (cand_rd),
      .all_wr  (cand_wr),
      .sb_vld  (sb_vld),
      .sb_rd   (sb_rd),
      .sb_rdy  (sb_rdy),
      .dep_hold(dep_hold_w[i]),
      .sb_hold (sb_hold_w[i]),
      .sel_a   (raw_sel_a_w[i*SW +: SW]),
      .sel_b   (raw_sel_b_w[i*SW +: SW])
    );
    assign blk_w[i] = dep_hold_w[i] | sb_hold_w[i];
  end

  gu_prefix #(.NSLOT(NSLOT), .MAX_FPG(MAX_FPG), .CW(CW)) pfx_i (
    .vld    (cand_vld),
    .fpg    (cand_fpg),
    .blk    (blk_w),
    .mask   (grp_mask_w),
    .cnt    (grp_cnt_w),
    .fpg_cut(fpg_cut_w)
  );

  logic [CW-1:0]       cnt_d;
  logic [NSLOT-1:0]    rint_d, rfpg_d;
  logic [NSLOT*SW-1:0] sela_d, selb_d;

  always_comb begin
    cnt_d  = '0;
    rint_d = '0;
    rfpg_d = '0;
    sela_d = '0;
    selb_d = '0;
    if (!stall_in) begin
      cnt_d  = grp_cnt_w;
      rint_d = grp_mask_w & ~cand_fpg;
      rfpg_d = grp_mask_w &  cand_fpg;
      for (int i = 0; i < NSLOT; i++) begin
        if (grp_mask_w[i]) begin
          sela_d[i*SW +: SW] = raw_sel_a_w[i*SW +: SW];
          selb_d[i*SW +: SW] = raw_sel_b_w[i*SW +: SW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_cnt <= '0;
      route_int <= '0;
      route_fpg <= '0;
      byp_sel_a <= '0;
      byp_sel_b <= '0;
    end else begin
      issue_cnt <= cnt_d;
      route_int <= rint_d;
      route_fpg <= rfpg_d;
      byp_sel_a <= sela_d;
      byp_sel_b <= selb_d;
    end
  end

endmodule

// File: rtl/gu_issue_group_chk.sv
module gu_issue_group_chk #(
  parameter int NSLOT   = 4,
  parameter int NSB     = 3,
  parameter int MAX_FPG = 2,
  parameter int CW      = $clog2(NSLOT + 1),
  parameter int SW      = $clog2(NSB + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stall_in,
  input logic [NSB-1:0]      sb_vld,
  input logic [NSB-1:0]      sb_rdy,
  input logic [CW-1:0]       issue_cnt,
  input logic [NSLOT-1:0]    route_int,
  input logic [NSLOT-1:0]    route_fpg,
  input logic [NSLOT*SW-1:0] byp_sel_a,
  input logic [NSLOT*SW-1:0] byp_sel_b
);

  logic [NSLOT-1:0] routed, therm;
  logic [NSB-1:0]   fwd_ok_q;

  assign routed = route_int | route_fpg;

  always_comb begin
    therm = '0;
    for (int i = 0; i < NSLOT; i++)
      therm[i] = (i < int'(issue_cnt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_ok_q <= '0;
    else        fwd_ok_q <= sb_vld & sb_rdy;
  end

  // R2
  issue_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    routed == therm);

  // R2
  issue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_cnt) <= NSLOT);

  // R3
  fpg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(route_fpg) <= MAX_FPG);

  // R8
  route_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_int & route_fpg) == '0);

  // R9
  stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_in |=> (issue_cnt == '0 && routed == '0 &&
                  byp_sel_a == '0 && byp_sel_b == '0));

  for (genvar i = 0; i < NSLOT; i++) begin : g_sel
    // R7
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !routed[i] |-> (byp_sel_a[i*SW +: SW] == '0 && byp_sel_b[i*SW +: SW] == '0));

    // R4
    sel_a_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_sel_a[i*SW +: SW] != '0) |->
        fwd_ok_q[int'(byp_sel_a[i*SW +: SW]) - 1]);

    // R4
    sel_b_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_sel_b[i*SW +: SW] != '0) |->
        fwd_ok_q[int'(byp_sel_b[i*SW +: SW]) - 1]);
  end

endmodule

bind gu_issue_group gu_issue_group_chk #(
  .NSLOT(NSLOT), .NSB(NSB), .MAX_FPG(MAX_FPG), .CW(CW), .SW(SW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stall_in(stall_in),
  .sb_vld(sb_vld), .sb_rdy(sb_rdy),
  .issue_cnt(issue_cnt), .route_int(route_int), .route_fpg(route_fpg),
  .byp_sel_a(byp_sel_a), .byp_sel_b(byp_sel_b)
);

// File: tb/gu_issue_group_tb.sv
`timescale 1ns/1ps
module gu_issue_group_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_in = 1'b0;
  logic [3:0]  cand_vld = '0, cand_fpg = '0, cand_wr = '0;
  logic [19:0] cand_rs1 = '0, cand_rs2 = '0, cand_rd = '0;
  logic [2:0]  sb_vld = '0, sb_rdy = '0;
  logic [14:0] sb_rd = '0;
  logic [2:0]  issue_cnt;
  logic [3:0]  route_int, route_fpg;
  logic [7:0]  byp_sel_a, byp_sel_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gu_issue_group dut_i (
    .clk(clk), .rst_n(rst_n), .stall_in(stall_in),
    .cand_vld(cand_vld), .cand_fpg(cand_fpg),
    .cand_rs1(cand_rs1), .cand_rs2(cand_rs2), .cand_rd(cand_rd),
    .cand_wr(cand_wr), .sb_vld(sb_vld), .sb_rd(sb_rd), .sb_rdy(sb_rdy),
    .issue_cnt(issue_cnt), .route_int(route_int), .route_fpg(route_fpg),
    .byp_sel_a(byp_sel_a), .byp_sel_b(byp_sel_b)
  );

  // Expected results
  logic [2:0] e_cnt;
  logic [3:0] e_int, e_fpg;
  logic [7:0] e_sa, e_sb;

  function automatic logic [4:0] fld5(input logic [19:0] v, input int i);
    return v[i*5 +: 5];
  endfunction

  // Bypass code for one source: scan youngest first, stop at first hit.
  function automatic logic [2:0] probe(input logic [4:0] r);
    // bit2 = not-ready hit, bits1:0 = code
    if (r == 5'd0) return 3'b000;
    for (int k = 0; k < 3; k++)
      if (sb_vld[k] && sb_rd[k*5 +: 5] == r)
        return {~sb_rdy[k], 2'(k + 1)};
    return 3'b000;
  endfunction

  task automatic model();
    int n = 0, fcount = 0;
    bit stop = 0;
    e_cnt = 0; e_int = 0; e_fpg = 0; e_sa = 0; e_sb = 0;
    if (stall_in) return;
    while (n < 4 && !stop) begin
      logic [2:0] pa, pb;
      logic [4:0] a, b;
      bit dep = 0;
      a = fld5(cand_rs1, n); b = fld5(cand_rs2, n);
      pa = probe(a); pb = probe(b);
      for (int j = 0; j < n; j++)
        if (cand_wr[j] && fld5(cand_rd, j) != 0 &&
            (fld5(cand_rd, j) == a || fld5(cand_rd, j) == b)) dep = 1;
      if (!cand_vld[n] || dep || pa[2] || pb[2] ||
          (cand_fpg[n] && fcount == 2)) stop = 1;
      else begin
        if (cand_fpg[n]) begin e_fpg[n] = 1; fcount++; end
        else e_int[n] = 1;
        e_sa[n*2 +: 2] = pa[1:0];
        e_sb[n*2 +: 2] = pb[1:0];
        n++;
      end
    end
    e_cnt = 3'(n);
  endtask

  task automatic check(input string tag);
    total++;
    if (issue_cnt !== e_cnt || route_int !== e_int || route_fpg !== e_fpg ||
        byp_sel_a !== e_sa || byp_sel_b !== e_sb) begin
      bad++;
      $display("FAIL %s: got cnt=%0d int=%b fpg=%b sa=%h sb=%h exp cnt=%0d int=%b fpg=%b sa=%h sb=%h",
               tag, issue_cnt, route_int, route_fpg, byp_sel_a, byp_sel_b,
               e_cnt, e_int, e_fpg, e_sa, e_sb);
    end
  endtask

  // Inputs are changed at the falling edge; the result is read just after
  // the next rising edge, one register later.
  task automatic apply(input string tag);
    model();
    @(posedge clk); #1;
    check(tag);
    @(negedge clk);
  endtask

  task automatic clear_in();
    stall_in = 0; cand_vld = 0; cand_fpg = 0; cand_wr = 0;
    cand_rs1 = 0; cand_rs2 = 0; cand_rd = 0;
    sb_vld = 0; sb_rdy = 0; sb_rd = 0;
  endtask

  task automatic set_slot(input int i, input bit f, input int s1, input int s2,
                          input int d, input bit w);
    cand_vld[i] = 1; cand_fpg[i] = f;
    cand_rs1[i*5 +: 5] = 5'(s1); cand_rs2[i*5 +: 5] = 5'(s2);
    cand_rd[i*5 +: 5] = 5'(d); cand_wr[i] = w;
  endtask

  task automatic set_sb(input int k, input int d, input bit rdy);
    sb_vld[k] = 1; sb_rd[k*5 +: 5] = 5'(d); sb_rdy[k] = rdy;
  endtask

  task automatic four_int();
    clear_in();
    set_slot(0, 0, 1, 2, 10, 1);
    set_slot(1, 0, 3, 4, 11, 1);
    set_slot(2, 0, 5, 6, 12, 1);
    set_slot(3, 0, 7, 8, 13, 1);
  endtask

  initial begin
    @(negedge clk);
    four_int();
    @(posedge clk); #1;
    // R1: reset holds outputs at zero even with candidates present
    e_cnt = 0; e_int = 0; e_fpg = 0; e_sa = 0; e_sb = 0;
    check("R1 reset");
    @(negedge clk); rst_n = 1;

    // R1: one-cycle latency, R2 full group
    four_int();
    apply("R1/R2 four independent");
    // R1: before the edge the output still shows the old group
    clear_in();
    #1;
    total++;
    if (issue_cnt !== 3'd4) begin
      bad++; $display("FAIL R1 latency: got %0d exp 4", issue_cnt);
    end
    apply("R2 none valid");

    four_int(); cand_vld[2] = 0;
    apply("R2 gap at slot 2");

    four_int(); cand_fpg = 4'b0111;
    apply("R3 third fpg cut");

    four_int(); cand_fpg = 4'b1010;
    apply("R3/R8 two fpg mixed routes");

    four_int(); set_sb(1, 4, 0);
    apply("R4 not-ready interlock slot1");

    four_int(); set_sb(0, 6, 1); set_sb(2, 6, 0); set_sb(1, 1, 1);
    apply("R4/R7 youngest ready wins");

    four_int(); set_sb(0, 3, 0); set_sb(2, 3, 1);
    apply("R4 youngest not ready blocks");

    four_int(); cand_rs2[2*5 +: 5] = 5'd10;
    apply("R5 in-group dependency");

    four_int(); cand_wr[0] = 0; cand_rs2[2*5 +: 5] = 5'd10;
    apply("R5 no write no dependency");

    four_int();
    cand_rd[0 +: 5] = 0; cand_rs1[5 +: 5] = 0; cand_rs2[15 +: 5] = 0;
    set_sb(0, 0, 0);
    apply("R6 register zero");

    four_int(); set_sb(2, 8, 1); stall_in = 1;
    apply("R9 stall empties group");

    // Random mix over a small register range to provoke matches
    for (int it = 0; it < 3000; it++) begin
      clear_in();
      stall_in = ($urandom_range(0, 15) == 0);
      cand_vld = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      cand_fpg = 4'($urandom) & 4'($urandom);
      cand_wr  = 4'($urandom);
      for (int i = 0; i < 4; i++) begin
        cand_rs1[i*5 +: 5] = 5'($urandom_range(0, 9));
        cand_rs2[i*5 +: 5] = 5'($urandom_range(0, 9));
        cand_rd[i*5 +: 5]  = 5'($urandom_range(0, 9));
      end
      for (int k = 0; k < 3; k++) begin
        sb_vld[k] = $urandom_range(0, 1);
        sb_rdy[k] = ($urandom_range(0, 3) != 0);
        sb_rd[k*5 +: 5] = 5'($urandom_range(0, 9));
      end
      apply("R2/R3/R4/R5/R6/R7/R8/R9 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule